// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Engine

This block carries bytes from a serial receiver into system-memory buffers. A chain of descriptors in memory describes the buffers. A descriptor sits at a 24-bit address. That address is an 8-bit chain base placed above a 16-bit descriptor offset. The engine fetches the current descriptor over a simple memory master port, one byte per read. It then loads its buffer-address and remaining-count registers and stores the incoming stream into the buffer. It uses 16-bit writes where alignment and the remaining count allow them, and single-byte writes everywhere else.

When the remaining count reaches zero, the engine writes the received length back into the descriptor and follows the link to the next descriptor. A configured stop offset marks the descriptor the chain must never use. When the link lands on that offset, the engine halts, raises an overflow flag and refuses further receive data.

Each descriptor occupies eight bytes, stored little-endian:

| Offset | Size | Field |
|---|---|---|
| 0 | 2 bytes | Link to the next descriptor (16-bit offset) |
| 2 | 3 bytes | Buffer pointer (24-bit address) |
| 5 | 2 bytes | Received length (written by the engine) |
| 7 | 1 byte | Status byte (not touched by the engine) |

Top module: `rxchain_dma`

## Requirements
- R1: A descriptor field is addressed as {cfg_chain_base, current offset} + field offset. The descriptor is fetched as five single-byte reads at field offsets 0 to 4, in that order. Offsets 0–1 hold the 16-bit link and offsets 2–4 hold the 24-bit buffer pointer, both least significant byte first.
- R2: After a fetch, the buffer address starts at the buffer pointer and the remaining count starts at cfg_buf_len. No data byte is written before the pointer or at or beyond pointer + cfg_buf_len.
- R3: A data write is a 16-bit write (mem_word=1) when the buffer address is even and at least 2 bytes remain, and a byte write (mem_word=0, data on mem_wdata[7:0]) otherwise. In a 16-bit write, the earlier received byte goes on mem_wdata[7:0] at the even address. A 16-bit write never goes to an odd address.
- R4: Received bytes land in the buffer in arrival order, at consecutive addresses. The address advances by 1 after a byte write and by 2 after a word write, and the count falls by the same amount.
- R5: When the count reaches zero, the received length (cfg_buf_len) is written as two byte writes: low byte at field offset 5, then high byte at field offset 6. The status byte at offset 7 is left untouched.
- R6: After the length write-back, the current offset takes the fetched link value and the next fetch starts there.
- R7: If the new current offset equals cfg_err_desc, the engine fetches nothing more. It raises overflow, drops busy, and holds rx_ready low, so no further byte is accepted.
- R8: With enable high, a start pulse while not busy loads cfg_first_desc as the current offset and clears overflow. busy is high from the next cycle.
- R9: enable low returns the engine to idle at the next edge: busy low, rx_ready low, no memory request.
- R10: A memory request holds its address, direction, size and data unchanged until mem_gnt. Read data is taken from mem_rdata in the cycle after the grant.
- R11: rx_ready is low whenever the engine is not busy, and while a data write is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low forces idle |
| start | input | 1 | Begin at cfg_first_desc |
| cfg_chain_base | input | 8 | Upper address byte of every descriptor |
| cfg_first_desc | input | 16 | Offset of the first descriptor |
| cfg_err_desc | input | 16 | Offset of the descriptor the chain must not use |
| cfg_buf_len | input | 16 | Bytes per buffer |
| rx_valid | input | 1 | Receive byte available |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Engine accepts the receive byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = byte read |
| mem_word | output | 1 | Write size: 1 = 16 bits, 0 = 8 bits |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 16 | Write data, low byte at the lower address |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rdata | input | 8 | Read byte, valid the cycle after the grant |
| busy | output | 1 | Chain walk in progress |
| overflow | output | 1 | Chain reached the stop offset |

## Verification
The assertions watch, on every cycle, the port-level rules:
- word writes are even-aligned;
- a request stays stable until granted;
- rx_ready stays low while idle or while a write is pending;
- disable reaches idle in one edge;
- start clears overflow and raises busy;
- overflow coincides with a quiet port.

Only the bench scenarios can show the following, because they need the memory image and the received stream:
- data placement and ordering;
- the exact byte/word write sequence for each start alignment and length;
- the length write-back and the untouched status byte;
- link following and the halt before the stop descriptor.

// File: rtl/rxchain_pkg.sv
package rxchain_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_FREQ,
      S_FDAT,
      S_FILL,
      S_WBREQ,
      S_STOP
   } seq_state_e;

   // byte offsets of descriptor fields
   localparam logic [2:0] FLD_LINK_LO = 3'd0;
   localparam logic [2:0] FLD_PTR_HI  = 3'd4;
   localparam logic [2:0] FLD_LEN_LO  = 3'd5;
   localparam logic [2:0] FLD_LEN_HI  = 3'd6;

endpackage

// File: rtl/rxchain_desc_addr.sv
module rxchain_desc_addr #(
   parameter int BASE_W          = 8,
   parameter int OFF_W           = 16,
   parameter bit CARRY_INTO_BASE = 1'b1
) (
   input  logic [BASE_W-1:0]        base,
   input  logic [OFF_W-1:0]         desc_off,
   input  logic [2:0]               field_off,
   output logic [BASE_W+OFF_W-1:0]  addr
);
   localparam int ADDR_W = BASE_W + OFF_W;

   generate
      if (CARRY_INTO_BASE) begin : g_full_add
         assign addr = {base, desc_off} + ADDR_W'(field_off);
      end else begin : g_wrap_add
         assign addr = {base, desc_off + OFF_W'(field_off)};
      end
   endgenerate
endmodule

// File: rtl/rxchain_packer.sv
module rxchain_packer #(
   parameter int CNT_W     = 16,
   parameter bit WORD_XFER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             addr_lsb,
   input  logic [CNT_W-1:0] remain,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   output logic             rx_ready,
   input  logic             gnt,
   output logic             wr_req,
   output logic [15:0]      wr_data,
   output logic             wr_word,
   output logic             step_done,
   output logic             step_two
);
   logic       have_lo;
   logic [7:0] lo_byte;
   logic       pend;
   logic       pend_word;
   logic [15:0] hold;
   logic       want_word;
   logic       accept;

   generate
      if (WORD_XFER) begin : g_word
         assign want_word = !addr_lsb && (remain >= CNT_W'(2));
      end else begin : g_byte
         assign want_word = 1'b0;
      end
   endgenerate

   assign rx_ready  = en && !pend;
   assign accept    = rx_valid && rx_ready;
   assign wr_req    = pend;
   assign wr_data   = hold;
   assign wr_word   = pend_word;
   assign step_done = pend && gnt;
   assign step_two  = pend_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_lo   <= 1'b0;
         lo_byte   <= '0;
         pend      <= 1'b0;
         pend_word <= 1'b0;
         hold      <= '0;
      end else if (!en) begin
         have_lo   <= 1'b0;
         pend      <= 1'b0;
         pend_word <= 1'b0;
      end else begin
         if (pend && gnt) begin
            pend <= 1'b0;
         end
         if (accept) begin
            if (want_word && !have_lo) begin
               lo_byte <= rx_data;
               have_lo <= 1'b1;
            end else if (want_word) begin
               hold      <= {rx_data, lo_byte};
               pend      <= 1'b1;
               pend_word <= 1'b1;
               have_lo   <= 1'b0;
            end else begin
               hold      <= {8'h00, rx_data};
               pend      <= 1'b1;
               pend_word <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/rxchain_seq.sv
module rxchain_seq
   import rxchain_pkg::*;
#(
   parameter int OFF_W  = 16,
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic [OFF_W-1:0]  first_desc,
   input  logic [OFF_W-1:0]  err_desc,
   input  logic [CNT_W-1:0]  buf_len,
   input  logic              mem_gnt,
   input  logic [7:0]        mem_rdata,
   input  logic              step_done,
   input  logic              step_two,
   output logic              fill_en,
   output logic [OFF_W-1:0]  cda,
   output logic [2:0]        field_off,
   output logic              sq_req,
   output logic              sq_we,
   output logic [7:0]        sq_wdata,
   output logic [ADDR_W-1:0] bar,
   output logic [CNT_W-1:0]  bcr,
   output logic              busy,
   output logic              overflow
);
   seq_state_e        state;
   logic [2:0]        idx;
   logic [OFF_W-1:0]  link;
   logic [15:0]       ptr_lo;
   logic [CNT_W-1:0]  blen;
   logic [CNT_W-1:0]  stp;

   assign stp       = step_two ? CNT_W'(2) : CNT_W'(1);
   assign fill_en   = (state == S_FILL);
   assign busy      = (state == S_FREQ) || (state == S_FDAT) ||
                      (state == S_FILL) || (state == S_WBREQ);
   assign sq_req    = (state == S_FREQ) || (state == S_WBREQ);
   assign sq_we     = (state == S_WBREQ);
   assign sq_wdata  = (idx == 3'd0) ? blen[7:0] : blen[15:8];
   assign field_off = (state == S_WBREQ) ? ((idx == 3'd0) ? FLD_LEN_LO : FLD_LEN_HI)
                                         : idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         link     <= '0;
         ptr_lo   <= '0;
         blen     <= '0;
         cda      <= '0;
         bar      <= '0;
         bcr      <= '0;
         overflow <= 1'b0;
      end else if (!enable) begin
         state <= S_IDLE;
      end else begin
         case (state)
            S_IDLE, S_STOP: begin
               if (start) begin
                  cda      <= first_desc;
                  overflow <= 1'b0;
                  idx      <= FLD_LINK_LO;
                  state    <= S_FREQ;
               end
            end
            S_FREQ: begin
               if (mem_gnt) state <= S_FDAT;
            end
            S_FDAT: begin
               case (idx)
                  3'd0:    link[7:0]    <= mem_rdata;
                  3'd1:    link[15:8]   <= mem_rdata;
                  3'd2:    ptr_lo[7:0]  <= mem_rdata;
                  3'd3:    ptr_lo[15:8] <= mem_rdata;
                  default: ;
               endcase
               if (idx == FLD_PTR_HI) begin
                  bar   <= {mem_rdata, ptr_lo};
                  bcr   <= buf_len;
                  blen  <= buf_len;
                  idx   <= '0;
                  state <= (buf_len == '0) ? S_WBREQ : S_FILL;
               end else begin
                  idx   <= idx + 3'd1;
                  state <= S_FREQ;
               end
            end
            S_FILL: begin
               if (step_done) begin
                  bar <= bar + ADDR_W'(stp);
                  bcr <= bcr - stp;
                  if (bcr == stp) begin
                     idx   <= '0;
                     state <= S_WBREQ;
                  end
               end
            end
            S_WBREQ: begin
               if (mem_gnt) begin
                  if (idx == 3'd0) begin
                     idx <= 3'd1;
                  end else begin
                     cda <= link;
                     idx <= '0;
                     if (link == err_desc) begin
                        overflow <= 1'b1;
                        state    <= S_STOP;
                     end else begin
                        state <= S_FREQ;
                     end
                  end
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxchain_dma.sv
module rxchain_dma #(
   parameter int BASE_W          = 8,
   parameter int OFF_W           = 16,
   parameter int CNT_W           = 16,
   parameter bit WORD_XFER       = 1'b1,
   parameter bit CARRY_INTO_BASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start,
   input  logic [BASE_W-1:0] cfg_chain_base,
   input  logic [OFF_W-1:0]  cfg_first_desc,
   input  logic [OFF_W-1:0]  cfg_err_desc,
   input  logic [CNT_W-1:0]  cfg_buf_len,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   output logic              rx_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_word,
   output logic [BASE_W+OFF_W-1:0] mem_addr,
   output logic [15:0]       mem_wdata,
   input  logic              mem_gnt,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              overflow
);
   localparam int ADDR_W = BASE_W + OFF_W;

   initial begin
      assert (BASE_W == 8)  else $error("descriptor layout needs an 8-bit base");
      assert (OFF_W == 16)  else $error("descriptor link field is 16 bits");
      assert (CNT_W == 16)  else $error("length field is 16 bits");
   end

   logic              fill_en;
   logic [OFF_W-1:0]  cda;
   logic [2:0]        field_off;
   logic              sq_req, sq_we;
   logic [7:0]        sq_wdata;
   logic [ADDR_W-1:0] bar;
   logic [CNT_W-1:0]  bcr;
   logic [ADDR_W-1:0] desc_addr;
   logic              pk_req, pk_word, step_done, step_two;
   logic [15:0]       pk_data;

   rxchain_seq #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk, .rst_n, .enable, .start,
      .first_desc (cfg_first_desc),
      .err_desc   (cfg_err_desc),
      .buf_len    (cfg_buf_len),
      .mem_gnt, .mem_rdata,
      .step_done, .step_two,
      .fill_en, .cda, .field_off,
      .sq_req, .sq_we, .sq_wdata,
      .bar, .bcr, .busy, .overflow
   );

   rxchain_desc_addr #(.BASE_W(BASE_W), .OFF_W(OFF_W),
                       .CARRY_INTO_BASE(CARRY_INTO_BASE)) u_daddr (
      .base      (cfg_chain_base),
      .desc_off  (cda),
      .field_off (field_off),
      .addr      (desc_addr)
   );

   rxchain_packer #(.CNT_W(CNT_W), .WORD_XFER(WORD_XFER)) u_pack (
      .clk, .rst_n,
      .en        (fill_en),
      .addr_lsb  (bar[0]),
      .remain    (bcr),
      .rx_valid, .rx_data, .rx_ready,
      .gnt       (mem_gnt & fill_en),
      .wr_req    (pk_req),
      .wr_data   (pk_data),
      .wr_word   (pk_word),
      .step_done, .step_two
   );

   assign mem_req   = fill_en ? pk_req  : sq_req;
   assign mem_we    = fill_en ? 1'b1    : sq_we;
   assign mem_word  = fill_en & pk_word;
   assign mem_addr  = fill_en ? bar     : desc_addr;
   assign mem_wdata = fill_en ? pk_data : {8'h00, sq_wdata};
endmodule

// File: rtl/rxchain_dma_chk.sv
module rxchain_dma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enable,
   input logic        start,
   input logic        rx_ready,
   input logic        mem_req,
   input logic        mem_we,
   input logic        mem_word,
   input logic [23:0] mem_addr,
   input logic [15:0] mem_wdata,
   input logic        mem_gnt,
   input logic        busy,
   input logic        overflow
);
   p_word_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_word |-> !mem_addr[0]);

   p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt && enable |=> mem_req && $stable(mem_addr) &&
      $stable(mem_we) && $stable(mem_word) && $stable(mem_wdata));

   p_idle_no_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rx_ready);

   p_write_blocks_rx_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> !rx_ready);

   p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> !busy && !mem_req && !rx_ready);

   p_disable_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !busy && !mem_req);

   p_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && enable && start |=> busy && !overflow);
endmodule

bind rxchain_dma rxchain_dma_chk u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
   .rx_ready(rx_ready), .mem_req(mem_req), .mem_we(mem_we),
   .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_gnt(mem_gnt), .busy(busy), .overflow(overflow)
);

// File: tb/sim_rxchain_dma.sv
module sim_rxchain_dma;
   localparam logic [7:0] BASE = 8'h3C;
   localparam logic [7:0] DPG  = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, start = 1'b0;
   logic [15:0] cfg_first_desc = '0, cfg_err_desc = '0, cfg_buf_len = '0;
   logic rx_valid = 1'b0;
   logic [7:0] rx_data;
   logic rx_ready, mem_req, mem_we, mem_word, mem_gnt = 1'b0, busy, overflow;
   logic [23:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [7:0]  mem_rdata = '0;

   int checks = 0, failures = 0;
   int unsigned rx_idx = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic [7:0]  mem [logic [23:0]];
   logic [23:0] qa [$];
   bit          qw [$];
   int          bad_addr = 0, eda_hits = 0;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] pat(input int unsigned i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   assign rx_data = pat(rx_idx);

   rxchain_dma u0 (
      .clk, .rst_n, .enable, .start,
      .cfg_chain_base(BASE), .cfg_first_desc, .cfg_err_desc, .cfg_buf_len,
      .rx_valid, .rx_data, .rx_ready,
      .mem_req, .mem_we, .mem_word, .mem_addr, .mem_wdata,
      .mem_gnt, .mem_rdata, .busy, .overflow
   );

   // random grant and source gaps, driven away from the active edge
   always @(negedge clk) begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_gnt  <= lfsr[0] | lfsr[3];
      rx_valid <= lfsr[5] | lfsr[8];
   end

   always @(posedge clk) begin
      if (rx_valid && rx_ready) rx_idx <= rx_idx + 1;
      if (mem_req && mem_gnt) begin
         if (mem_addr[23:16] != BASE && mem_addr[23:16] != DPG) bad_addr++;
         if (mem_addr[23:16] == BASE && mem_addr[15:0] >= cfg_err_desc &&
             mem_addr[15:0] < cfg_err_desc + 16'd8) eda_hits++;
         if (mem_we) begin
            mem[mem_addr] = mem_wdata[7:0];
            if (mem_word) mem[mem_addr + 24'd1] = mem_wdata[15:8];
            if (mem_addr[23:16] == DPG) begin
               qa.push_back(mem_addr);
               qw.push_back(mem_word);
            end
         end else begin
            mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_desc(input logic [15:0] off, input logic [15:0] link,
                           input logic [23:0] bp);
      logic [23:0] a;
      a = {BASE, off};
      mem[a]         = link[7:0];
      mem[a + 24'd1] = link[15:8];
      mem[a + 24'd2] = bp[7:0];
      mem[a + 24'd3] = bp[15:8];
      mem[a + 24'd4] = bp[23:16];
      mem[a + 24'd5] = 8'hFF;
      mem[a + 24'd6] = 8'hFF;
      mem[a + 24'd7] = 8'hEE;
   endtask

   task automatic verify_buf(input logic [15:0] d, input logic [23:0] bp,
                             input int len, input int unsigned first);
      int mism = 0;
      logic [23:0] a, da;
      int c;
      for (int k = 0; k < len; k++) begin
         a = bp + 24'(k);
         if (!mem.exists(a) || mem[a] != pat(first + k)) mism++;
      end
      chk(mism == 0, "R4", "buffer data mismatches", mism, 0);
      chk(!mem.exists(bp + 24'(len)) && !mem.exists(bp - 24'd1), "R2",
          "write outside buffer", 1, 0);
      da = {BASE, d};
      chk({mem[da + 24'd6], mem[da + 24'd5]} == 16'(len), "R5", "length field",
          {mem[da + 24'd6], mem[da + 24'd5]}, len);
      chk(mem[da + 24'd7] == 8'hEE, "R5", "status byte", mem[da + 24'd7], 8'hEE);
      // expected write sequence, arithmetic
      mism = 0;
      a = bp;
      c = len;
      while (c > 0) begin
         bit w = !a[0] && c >= 2;
         if (qa.size() == 0) mism++;
         else begin
            if (qa[0] != a || qw[0] != w) mism++;
            void'(qa.pop_front());
            void'(qw.pop_front());
         end
         a = a + (w ? 24'd2 : 24'd1);
         c = c - (w ? 2 : 1);
      end
      chk(mism == 0, "R3", "byte/word write sequence errors", mism, 0);
   endtask

   task automatic kick();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(busy && !overflow, "R8", "busy/overflow after start", {busy, overflow}, 2'b10);
   endtask

   task automatic wait_stop(input int unsigned idx0, input int total);
      int unsigned after;
      for (int i = 0; i < 4000 && !overflow; i++) @(negedge clk);
      chk(overflow && !busy && !rx_ready, "R7", "stopped state",
          {overflow, busy, rx_ready}, 3'b100);
      chk(rx_idx - idx0 == total, "R7", "bytes accepted", rx_idx - idx0, total);
      after = rx_idx;
      repeat (20) @(negedge clk);
      chk(rx_idx == after, "R7", "bytes accepted after stop", rx_idx, after);
      chk(eda_hits == 0, "R7", "stop descriptor accessed", eda_hits, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned idx0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !overflow && !rx_ready && !mem_req, "R11", "reset state",
          {busy, overflow, rx_ready, mem_req}, 0);
      enable = 1'b1;

      // three-buffer chain, mixed alignment, then overflow (R1, R6)
      put_desc(16'h0100, 16'h0110, {DPG, 16'h2001});
      put_desc(16'h0110, 16'h0120, {DPG, 16'h3000});
      put_desc(16'h0120, 16'h0130, {DPG, 16'h4003});
      cfg_first_desc = 16'h0100;
      cfg_err_desc   = 16'h0130;
      cfg_buf_len    = 16'd7;
      eda_hits = 0;
      idx0 = rx_idx;
      kick();
      wait_stop(idx0, 21);
      verify_buf(16'h0100, {DPG, 16'h2001}, 7, idx0);
      verify_buf(16'h0110, {DPG, 16'h3000}, 7, idx0 + 7);
      verify_buf(16'h0120, {DPG, 16'h4003}, 7, idx0 + 14);
      chk(bad_addr == 0, "R1", "accesses outside base/data pages", bad_addr, 0);

      // sweep of lengths and start alignments, single buffer each
      for (int len = 1; len <= 6; len++) begin
         for (int al = 0; al < 2; al++) begin
            mem.delete();
            qa.delete();
            qw.delete();
            put_desc(16'h0200, 16'h0300, {DPG, 16'h6000} + 24'(al));
            cfg_first_desc = 16'h0200;
            cfg_err_desc   = 16'h0300;
            cfg_buf_len    = 16'(len);
            eda_hits = 0;
            idx0 = rx_idx;
            kick();
            wait_stop(idx0, len);
            verify_buf(16'h0200, {DPG, 16'h6000} + 24'(al), len, idx0);
         end
      end
      chk(bad_addr == 0, "R1", "accesses outside base/data pages", bad_addr, 0);

      // disable mid-transfer (R9)
      mem.delete();
      put_desc(16'h0400, 16'h0500, {DPG, 16'h7000});
      cfg_first_desc = 16'h0400;
      cfg_err_desc   = 16'h0500;
      cfg_buf_len    = 16'd40;
      kick();
      repeat (15) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      chk(!busy && !rx_ready && !mem_req, "R9", "idle after disable",
          {busy, rx_ready, mem_req}, 0);
      enable = 1'b1;
      repeat (5) @(negedge clk);
      chk(!busy && !rx_ready, "R9", "stays idle without start", {busy, rx_ready}, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule